// File: doc/BRIEF.md
# Scan-Loadable Four-State Control Sequencer

This block is a small control sequencer with four states: waiting, active, finished and faulted. In normal operation it reacts to four single-bit commands. A start request launches activity. A finish indication completes it. An acknowledge returns the machine to waiting. A clear forces waiting from any state. If start and finish are both high while the machine is active, that combination is illegal and sends it to the faulted state, which it leaves only on a clear. Three status flags are decoded straight from the two state flops.

For production test, the two state flops also form a serial shift path. When the shift enable is high, every clock moves the path one bit along. The bit order is: serial input into state bit 0, state bit 0 into state bit 1, and state bit 1 drives the serial output. A tester can therefore shift in any state, apply one functional capture clock, and shift the result out. The asynchronous reset is ignored while the test-mode pin is high, so a reset pulse cannot destroy a state that has already been loaded.

Top module: `scanfsm_top`

## Requirements
- R1: With test_mode low, rst_n low asynchronously forces state 00 (waiting). In that state busy_o, done_o, err_o and scan_out are all 0.
- R2: From state 00 with scan_en low and clr low, start=1 moves the machine to state 01 (active) on the next clock. With start=0 it stays in 00.
- R3: From state 01 with scan_en low and clr low, fin=1 and start=0 move the machine to state 10 (finished). fin=0 keeps it in 01.
- R4: From state 01 with scan_en low and clr low, start=1 and fin=1 together move the machine to state 11 (faulted). State 11 holds for as long as clr stays low.
- R5: From state 10 with scan_en low and clr low, ack=1 returns the machine to 00. ack=0 keeps it in 10.
- R6: With scan_en low, clr=1 sends the machine to 00 on the next clock from any state, overriding start, fin and ack.
- R7: With scan_en high, each clock loads state bit 0 from scan_in and state bit 1 from the old state bit 0. start, fin, ack and clr are ignored, including clr.
- R8: scan_out always equals state bit 1.
- R9: With test_mode high, rst_n low has no effect on the state.
- R10: busy_o is 1 only in state 01, done_o only in state 10, and err_o only in state 11. At most one of the three is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, ignored when test_mode is high |
| test_mode | input | 1 | Test mode; blocks the reset |
| scan_en | input | 1 | 1 = shift the state chain, 0 = functional capture |
| scan_in | input | 1 | Serial data into state bit 0 |
| start | input | 1 | Start request |
| fin | input | 1 | Finish indication |
| ack | input | 1 | Acknowledge of completion |
| clr | input | 1 | Clear to waiting state |
| scan_out | output | 1 | Serial data out, equal to state bit 1 |
| busy_o | output | 1 | High in the active state |
| done_o | output | 1 | High in the finished state |
| err_o | output | 1 | High in the faulted state |

## Verification
The status flags and scan_out follow the state register through decode logic only. A capture or shift applied at one rising edge therefore appears on every output within that same clock period, one register stage after the inputs were driven. The bench drives its inputs at the falling edge and updates its own model at the rising edge. It compares all four outputs one nanosecond after the rising edge, so each result is checked in the cycle in which it becomes due. An asynchronous reset takes effect immediately and is still held at the next rising edge, so the model applies it at that edge. The directed shift sequences check the expected scan_out bit after each individual shift clock.

// File: rtl/scanfsm_pkg.sv
package scanfsm_pkg;

    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10,
        ST_ERR  = 2'b11
    } ctl_state_e;

    typedef struct packed {
        logic start;
        logic fin;
        logic ack;
        logic clr;
    } ctl_cmd_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic err;
    } ctl_flags_t;

endpackage

// File: rtl/scanfsm_next.sv
module scanfsm_next
    import scanfsm_pkg::*;
(
    input  ctl_state_e cur_q,
    input  ctl_cmd_t   cmd,
    output ctl_state_e func_d
);

    always_comb begin
        func_d = cur_q;
        if (cmd.clr) begin
            func_d = ST_IDLE;
        end else begin
            unique case (cur_q)
                ST_IDLE: if (cmd.start) func_d = ST_RUN;
                ST_RUN: begin
                    if (cmd.start && cmd.fin) func_d = ST_ERR;
                    else if (cmd.fin)         func_d = ST_DONE;
                end
                ST_DONE: if (cmd.ack) func_d = ST_IDLE;
                ST_ERR:  func_d = ST_ERR;
                default: func_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scanfsm_chain.sv
module scanfsm_chain #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_gn,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [W-1:0] func_d,
    output logic [W-1:0] state_q,
    output logic         scan_out
);

    logic [W-1:0] shift_d;
    logic [W-1:0] state_d;

    for (genvar i = 0; i < W; i++) begin : g_link
        if (i == 0) begin : g_head
            assign shift_d[i] = scan_in;
        end else begin : g_body
            assign shift_d[i] = state_q[i-1];
        end
    end

    always_comb begin
        state_d = scan_en ? shift_d : func_d;
    end

    always_ff @(posedge clk or negedge rst_gn) begin
        if (!rst_gn) state_q <= '0;
        else         state_q <= state_d;
    end

    assign scan_out = state_q[W-1];

endmodule

// File: rtl/scanfsm_decode.sv
module scanfsm_decode
    import scanfsm_pkg::*;
(
    input  ctl_state_e cur_q,
    output ctl_flags_t flags
);

    always_comb begin
        flags      = '0;
        flags.busy = (cur_q == ST_RUN);
        flags.done = (cur_q == ST_DONE);
        flags.err  = (cur_q == ST_ERR);
    end

endmodule

// File: rtl/scanfsm_top.sv
module scanfsm_top
    import scanfsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_en,
    input  logic scan_in,
    input  logic start,
    input  logic fin,
    input  logic ack,
    input  logic clr,
    output logic scan_out,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);

    logic            rst_gn;
    ctl_cmd_t        cmd;
    ctl_state_e      cur_q;
    ctl_state_e      func_d;
    logic [ST_W-1:0] state_q;
    ctl_flags_t      flags;

    assign rst_gn = rst_n | test_mode;
    assign cmd    = '{start: start, fin: fin, ack: ack, clr: clr};
    assign cur_q  = ctl_state_e'(state_q);

    scanfsm_next u_next (
        .cur_q  (cur_q),
        .cmd    (cmd),
        .func_d (func_d)
    );

    scanfsm_chain #(.W(ST_W)) u_chain (
        .clk      (clk),
        .rst_gn   (rst_gn),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .func_d   (func_d),
        .state_q  (state_q),
        .scan_out (scan_out)
    );

    scanfsm_decode u_decode (
        .cur_q (cur_q),
        .flags (flags)
    );

    assign busy_o = flags.busy;
    assign done_o = flags.done;
    assign err_o  = flags.err;

endmodule

// File: rtl/scanfsm_checker.sv
module scanfsm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       test_mode,
    input logic       scan_en,
    input logic       scan_in,
    input logic       start,
    input logic       fin,
    input logic       ack,
    input logic       clr,
    input logic       scan_out,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic [1:0] state_q
);

    logic rst_act;
    assign rst_act = !rst_n && !test_mode;

    logic func_go;
    assign func_go = !scan_en && !clr;

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst_act)
        (state_q == 2'b00 && func_go && start) |=> (state_q == 2'b01));

    assert_run_finish_R3: assert property (@(posedge clk) disable iff (rst_act)
        (state_q == 2'b01 && func_go && fin && !start) |=> (state_q == 2'b10));

    assert_err_hold_R4: assert property (@(posedge clk) disable iff (rst_act)
        (state_q == 2'b11 && func_go) |=> (state_q == 2'b11));

    assert_done_ack_R5: assert property (@(posedge clk) disable iff (rst_act)
        (state_q == 2'b10 && func_go && ack) |=> (state_q == 2'b00));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst_act)
        (!scan_en && clr) |=> (state_q == 2'b00));

    assert_shift_R7: assert property (@(posedge clk) disable iff (rst_act)
        scan_en |=> (state_q == {$past(state_q[0]), $past(scan_in)}));

    assert_scan_tail_R8: assert property (@(posedge clk) disable iff (rst_act)
        scan_en |=> (scan_out == $past(state_q[0])));

    assert_flags_R10: assert property (@(posedge clk) disable iff (rst_act)
        $onehot0({busy_o, done_o, err_o}));

endmodule

bind scanfsm_top scanfsm_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .start     (start),
    .fin       (fin),
    .ack       (ack),
    .clr       (clr),
    .scan_out  (scan_out),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .state_q   (state_q)
);

// File: tb/test_scanfsm_top.sv
`timescale 1ns/1ps
module test_scanfsm_top;

    logic clk = 1'b0;
    logic rst_n, test_mode, scan_en, scan_in, start, fin, ack, clr;
    logic scan_out, busy_o, done_o, err_o;

    int n_cmp  = 0;
    int n_fail = 0;
    logic [1:0] model;

    always #2 clk = ~clk;

    scanfsm_top i_scanfsm_top (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
        .scan_in(scan_in), .start(start), .fin(fin), .ack(ack), .clr(clr),
        .scan_out(scan_out), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [1:0] next_model(logic [1:0] s);
        if (!rst_n && !test_mode) return 2'b00;
        if (scan_en)              return {s[0], scan_in};
        if (clr)                  return 2'b00;
        case (s)
            2'b00: return start ? 2'b01 : 2'b00;
            2'b01: return (start && fin) ? 2'b11 : (fin ? 2'b10 : 2'b01);
            2'b10: return ack ? 2'b00 : 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] s);
        if (!rst_n && !test_mode) return "R1";
        if (!rst_n)               return "R9";
        if (scan_en)              return "R7";
        if (clr)                  return "R6";
        case (s)
            2'b00: return "R2";
            2'b01: return (start && fin) ? "R4" : "R3";
            2'b10: return "R5";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [3:0] expect_out(logic [1:0] s);
        return {s == 2'b01, s == 2'b10, s == 2'b11, s[1]};
    endfunction

    task automatic check(string tag);
        logic [3:0] act, exp;
        act = {busy_o, done_o, err_o, scan_out};
        exp = expect_out(model);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {busy,done,err,scan_out} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(logic tm, logic rn, logic se, logic si,
                         logic st, logic fi, logic ak, logic cl);
        @(negedge clk);
        test_mode = tm; rst_n = rn; scan_en = se; scan_in = si;
        start = st; fin = fi; ack = ak; clr = cl;
    endtask

    task automatic clock_check();
        string tag;
        @(posedge clk);
        tag   = tag_of(model);
        model = next_model(model);
        #1;
        check(tag);
        if (tag == "R7" || tag == "R9") check("R8");
    endtask

    task automatic step(logic tm, logic rn, logic se, logic si,
                        logic st, logic fi, logic ak, logic cl);
        drive(tm, rn, se, si, st, fi, ak, cl);
        clock_check();
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        test_mode = 0; rst_n = 0; scan_en = 0; scan_in = 0;
        start = 0; fin = 0; ack = 0; clr = 0;
        model = 2'b00;
        repeat (3) @(posedge clk);
        #1; check("R1");
        // walk all functional arcs
        step(0,1,0,0, 0,0,0,0);           // R2 stay in 00
        step(0,1,0,0, 1,0,0,0);           // R2 go 01
        step(0,1,0,0, 0,0,0,0);           // R3 hold 01
        step(0,1,0,0, 0,1,0,0);           // R3 go 10
        step(0,1,0,0, 0,0,0,0);           // R5 hold
        step(0,1,0,0, 0,0,1,0);           // R5 go 00
        step(0,1,0,0, 1,0,0,0);
        step(0,1,0,0, 1,1,0,0);           // R4 go 11
        step(0,1,0,0, 1,1,1,0);           // R4 holds
        step(0,1,0,0, 0,0,1,0);
        step(0,1,1,0, 0,0,0,1);           // R7 clr ignored while shifting
        step(0,1,0,0, 1,1,1,1);           // R6 clr wins
        // load 01 via chain: first 0 then 1
        step(1,1,1,0, 0,0,0,0);
        step(1,1,1,1, 0,0,0,1);           // R7
        // R9: reset in test mode leaves state 01
        step(1,0,0,0, 0,0,0,0);
        step(1,0,0,0, 0,0,0,0);
        // capture fin -> 10, then shift out
        step(1,1,0,0, 0,1,0,0);           // R3
        step(1,1,1,0, 0,0,0,0);           // R8 scan_out shows bit0=0
        step(1,1,1,0, 0,0,0,0);
        // reset returns to functional control
        drive(0,0,0,0, 0,0,0,0);
        #1; model = 2'b00; check("R1");
        step(0,1,0,0, 0,0,0,0);
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0] & r[1], (r[7:2] != 0), (r[10:8] == 3'd0), r[11],
                 r[12] | r[13], r[14] & r[15], r[16], (r[21:17] == 5'd0));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
    end

endmodule